// File: doc/BRIEF.md
# Windowed Watchdog with Shared Timing Register

This block supervises software with a windowed watchdog. The watchdog period is a base tick count multiplied by a divider. The divider comes from a 3-bit code. Each period has two halves. The first half is closed, and a refresh during it is a fault. The second half is open, and a refresh during it restarts the period. A missed refresh is also a fault. Either fault produces a one-cycle reset pulse, and the watchdog then starts counting again from zero.

Both the watchdog code and a separate 3-bit cyclic-wake interval code are written through one timing-register write port. A select bit in the written word decides which of the two codes takes the payload. Every timing-register write, and every status read, loads a 4-bit status word into a holding register. The timeout and error flags are cleared once that status word has been captured. An enable input turns the watchdog off, and the status word reports this.

Top module: `win_watchdog`

## Requirements
- R1: A timing write uses `tim_wdata[3]` as the select bit and `tim_wdata[2:0]` as the payload. With select = 1 the payload goes to `wake_code`. With select = 0 it goes to the watchdog code.
- R2: A select = 1 write neither restarts the watchdog count nor changes the watchdog period.
- R3: The period is P = D × BASE_TICKS, where D is 1, 2, 4, 6, 8, 10, 12 or 14 for codes 0 through 7. A select = 0 write restarts the count. If no valid refresh arrives, `wd_rst` is high just after the P-th rising edge that follows the restart edge.
- R4: The window is closed while fewer than P/2 cycles have passed since the restart. A refresh in that interval causes a reset pulse on the next cycle.
- R5: A refresh in the open window restarts the period without a reset. This includes a refresh on the last cycle of the period.
- R6: `wd_rst` is high for exactly one cycle. A refresh during that cycle is ignored.
- R7: The status word is laid out as [3] timeout flag, [2] window-error flag (the last fault was an early refresh), [1] watchdog off (`wd_en` low) and [0] window currently open. It is loaded into `status_q` on the edge that samples `tim_wr` or `stat_rd`.
- R8: After the capture, a timing write or a status read clears both flags. An expiry sets only the timeout flag.
- R9: While `wd_en` is low the count stays at zero, no fault occurs and refresh is ignored. After re-enabling, the period counts from zero.
- R10: During reset `status_q`, `wake_code` and `wd_rst` are all zero, and the watchdog code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wd_en | input | 1 | Watchdog enable |
| tim_wr | input | 1 | Timing-register write strobe |
| tim_wdata | input | 4 | Select bit [3] and 3-bit payload [2:0] |
| stat_rd | input | 1 | Status read strobe |
| refresh | input | 1 | Watchdog refresh (kick) |
| status_q | output | 4 | Captured status word |
| wake_code | output | 3 | Cyclic-wake interval code |
| wd_rst | output | 1 | One-cycle reset pulse on a watchdog fault |

## Verification
The bench measures the reset distance for several watchdog codes, so a wrong divider mapping or an off-by-one in the period compare shows up as a wrong cycle count. It places refreshes on the last closed cycle and on the first open cycle, so a window edge that is off by one either fires a spurious reset or misses a fault. It also refreshes on the final cycle of a period, where a design that lets the expiry win would reset. A select = 1 write is issued partway through a period, which exposes a design that restarts or recodes the watchdog on that write. A refresh during the reset pulse would cause a second fault if it were not ignored. Status captures taken right after faults and reads show flags that fail to clear, or clear before they are captured.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef struct packed {
    logic to_flag;
    logic err_flag;
    logic off;
    logic open;
  } wdg_stat_t;

  // divider selected by the 3-bit watchdog code
  function automatic logic [3:0] wd_div(input logic [2:0] code);
    return (code == 3'd0) ? 4'd1 : {code, 1'b0};
  endfunction

endpackage

// File: rtl/wdg_timreg.sv
module wdg_timreg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [3:0] wdata,
  output logic [2:0] wd_code,
  output logic [2:0] wake_code,
  output logic       wd_restart
);

  logic       sel;
  logic [2:0] wd_code_d, wake_code_d;

  assign sel        = wdata[3];
  assign wd_restart = wr & ~sel;

  always_comb begin
    wd_code_d   = wd_code;
    wake_code_d = wake_code;
    if (wr && sel)  wake_code_d = wdata[2:0];
    if (wr && !sel) wd_code_d   = wdata[2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_code   <= '0;
      wake_code <= '0;
    end else if (wr) begin
      wd_code   <= wd_code_d;
      wake_code <= wake_code_d;
    end
  end

  // R1
  wake_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[3]) |=> (wake_code == $past(wdata[2:0])));
  // R2
  wake_keeps_wd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[3]) |=> $stable(wd_code));

endmodule

// File: rtl/wdg_window.sv
module wdg_window #(
  parameter int BASE_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [2:0] code,
  input  logic       restart,
  input  logic       refresh,
  input  logic       blank,
  output logic       win_open,
  output logic       early,
  output logic       expire
);
  import wdg_pkg::*;

  localparam int MAX_PERIOD = 14 * BASE_TICKS;
  localparam int CW         = $clog2(MAX_PERIOD + 1);

  logic [CW-1:0] cnt, cnt_d, period, half;
  logic          kick, wrap;

  assign period   = CW'(wd_div(code)) * CW'(BASE_TICKS);
  assign half     = period >> 1;
  assign win_open = en && (cnt >= half);
  assign kick     = en && refresh && !blank;
  assign early    = kick && !win_open;
  assign wrap     = en && !kick && (cnt == period - CW'(1));
  assign expire   = wrap;

  always_comb begin
    if (!en || restart || kick || wrap) cnt_d = '0;
    else                                cnt_d = cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R3
  cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < period);
  // R9
  off_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
  // R5
  open_kick_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && refresh && !blank && win_open) |=> (cnt == '0));

endmodule

// File: rtl/wdg_status.sv
module wdg_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       win_open,
  input  logic       early,
  input  logic       expire,
  input  logic       cap,
  output logic [3:0] status_q,
  output logic       wd_rst
);
  import wdg_pkg::*;

  logic      to_q, err_q, to_d, err_d, fault;
  wdg_stat_t word;

  assign fault = early | expire;

  always_comb begin
    word.to_flag  = to_q;
    word.err_flag = err_q;
    word.off      = ~en;
    word.open     = win_open;
  end

  always_comb begin
    to_d  = to_q;
    err_d = err_q;
    if (fault) begin
      to_d  = 1'b1;
      err_d = early;
    end else if (cap) begin
      to_d  = 1'b0;
      err_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_q   <= 1'b0;
      err_q  <= 1'b0;
      wd_rst <= 1'b0;
    end else begin
      to_q   <= to_d;
      err_q  <= err_d;
      wd_rst <= fault;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   status_q <= '0;
    else if (cap) status_q <= word;
  end

  // R4
  fault_pulses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> wd_rst);
  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |=> !wd_rst);
  // R8
  cap_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !fault) |=> (!to_q && !err_q));
  // R7
  early_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    early |=> (err_q && to_q));

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int BASE_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wd_en,
  input  logic       tim_wr,
  input  logic [3:0] tim_wdata,
  input  logic       stat_rd,
  input  logic       refresh,
  output logic [3:0] status_q,
  output logic [2:0] wake_code,
  output logic       wd_rst
);

  logic [1:0] rst_sync;
  logic       rst_int_n;
  logic [2:0] wd_code;
  logic       wd_restart, win_open, early, expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  wdg_timreg u_timreg (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr         (tim_wr),
    .wdata      (tim_wdata),
    .wd_code    (wd_code),
    .wake_code  (wake_code),
    .wd_restart (wd_restart)
  );

  wdg_window #(.BASE_TICKS(BASE_TICKS)) u_window (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en       (wd_en),
    .code     (wd_code),
    .restart  (wd_restart),
    .refresh  (refresh),
    .blank    (wd_rst),
    .win_open (win_open),
    .early    (early),
    .expire   (expire)
  );

  wdg_status u_status (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en       (wd_en),
    .win_open (win_open),
    .early    (early),
    .expire   (expire),
    .cap      (tim_wr | stat_rd),
    .status_q (status_q),
    .wd_rst   (wd_rst)
  );

  initial begin
    // R3
    base_ticks_chk: assert (BASE_TICKS >= 2);
  end

endmodule

// File: tb/test_win_watchdog.sv
module test_win_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wd_en, tim_wr, stat_rd, refresh;
  logic [3:0] tim_wdata;
  logic [3:0] status_q;
  logic [2:0] wake_code;
  logic       wd_rst;

  int tests = 0;
  int fails = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  win_watchdog #(.BASE_TICKS(BASE)) i_win_watchdog (
    .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .tim_wr(tim_wr),
    .tim_wdata(tim_wdata), .stat_rd(stat_rd), .refresh(refresh),
    .status_q(status_q), .wake_code(wake_code), .wd_rst(wd_rst)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected status words as captures happen
  always @(posedge clk) begin
    if (tim_wr || stat_rd) begin
      #1;
      if (exp_q.size() == 0) begin
        check(0, "R7 unexpected capture", status_q, 0);
      end else begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(status_q == e, t, status_q, e);
      end
    end
  end

  task automatic wr(input bit sel, input logic [2:0] code, input logic [3:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    tim_wdata = {sel, code};
    tim_wr = 1'b1;
    @(posedge clk); #1;
    tim_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    stat_rd = 1'b1;
    @(posedge clk); #1;
    stat_rd = 1'b0;
  endtask

  task automatic measure(input int p, input string tag);
    int n = 0;
    while (wd_rst !== 1'b1 && n < 1000) begin
      @(posedge clk); #1;
      n++;
    end
    check(n == p, tag, n, p);
  endtask

  task automatic pulse_end(input bit kick);
    refresh = kick;
    @(posedge clk); #1;
    refresh = 1'b0;
    check(wd_rst == 1'b0, "R6 pulse width", wd_rst, 0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wd_en = 1'b1; tim_wr = 1'b0; stat_rd = 1'b0;
    refresh = 1'b0; tim_wdata = '0;
    repeat (3) @(posedge clk); #1;
    // R10
    check(wd_rst == 1'b0, "R10 reset wd_rst", wd_rst, 0);
    check(status_q == 4'd0, "R10 reset status", status_q, 0);
    check(wake_code == 3'd0, "R10 reset wake", wake_code, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;

    // R3 code 0, period 8
    wr(1'b0, 3'd0, 4'b0000, "R10 first status");
    measure(1 * BASE, "R3 code0 period");
    pulse_end(1'b0);
    rd(4'b1000, "R8 expiry sets timeout only");
    rd(4'b0000, "R8 read clears flags");

    // R3 codes 3 and 7
    wr(1'b0, 3'd3, 4'b0000, "R7 status on write");
    measure(6 * BASE, "R3 code3 period");
    pulse_end(1'b0);
    wr(1'b0, 3'd7, 4'b1000, "R8 write captures flag");
    measure(14 * BASE, "R3 code7 period");
    pulse_end(1'b0);

    // R4 early refresh on last closed cycle (P=16)
    wr(1'b0, 3'd1, 4'b1000, "R7 capture before clear");
    repeat (7) @(posedge clk);
    #1 refresh = 1'b1;
    @(posedge clk); #1;
    refresh = 1'b0;
    check(wd_rst == 1'b1, "R4 closed-window refresh", wd_rst, 1);
    rd(4'b1100, "R7 window error flags");

    // R5 refresh on first open cycle
    wr(1'b0, 3'd1, 4'b0000, "R8 flags cleared");
    repeat (8) @(posedge clk);
    #1 refresh = 1'b1;
    @(posedge clk); #1;
    refresh = 1'b0;
    measure(2 * BASE, "R5 open refresh restarts");
    pulse_end(1'b0);

    // R7 window-open bit
    wr(1'b0, 3'd1, 4'b1000, "R7 flag after expiry");
    repeat (8) @(posedge clk);
    #1 stat_rd = 1'b1;
    exp_q.push_back(4'b0001);
    tag_q.push_back("R7 open bit");
    @(posedge clk); #1;
    stat_rd = 1'b0;

    // R5 refresh on last cycle of period (P=8)
    wr(1'b0, 3'd0, 4'b0001, "R7 open at write");
    repeat (7) @(posedge clk);
    #1 refresh = 1'b1;
    @(posedge clk); #1;
    refresh = 1'b0;
    check(wd_rst == 1'b0, "R5 last-cycle refresh", wd_rst, 0);
    measure(1 * BASE, "R5 period after last-cycle refresh");
    // R6 refresh during pulse ignored
    pulse_end(1'b1);

    // R1 R2 select routing
    wr(1'b0, 3'd2, 4'b1000, "R6 no fault from pulse refresh");
    wr(1'b1, 3'd5, 4'b0000, "R1 wake write status");
    check(wake_code == 3'd5, "R1 wake code", wake_code, 5);
    measure(4 * BASE - 1, "R2 wake write keeps timing");
    pulse_end(1'b0);

    // R9 disabled
    wd_en = 1'b0;
    repeat (2) @(posedge clk); #1;
    rd(4'b1010, "R9 off bit");
    begin
      int hits = 0;
      for (int i = 0; i < 300; i++) begin
        refresh = i[2];
        @(posedge clk); #1;
        if (wd_rst) hits++;
      end
      refresh = 1'b0;
      check(hits == 0, "R9 no reset when off", hits, 0);
    end
    rd(4'b0010, "R9 refresh ignored when off");
    wd_en = 1'b1;
    measure(4 * BASE, "R9 restart from zero");

    repeat (3) @(posedge clk); #1;
    check(exp_q.size() == 0, "R7 all captures seen", exp_q.size(), 0);
    finish_run();
  end

endmodule